// File: doc/BRIEF.md
# Two-Stage Deadline Watchdog

This peripheral watches a free-running 64-bit system count, supplied as an input, against a programmable 64-bit deadline. Software keeps the deadline ahead of the count by refreshing. If the count reaches the deadline while the watchdog is enabled, the block raises a warning flag and interrupt. It then re-arms itself so that the new deadline lies one offset period beyond the count. If the count reaches that second deadline before any refresh, the block raises a reset-request flag and output. The block does not reset the rest of the system itself. A separate power-on reset clears the reset-request flag, so software can read the cause of the last system reset.

Access goes through a simple single-cycle register bus with two frames. `bus_frame` selects the frame: 0 is the refresh frame and 1 is the control frame. In the control frame, software reads and writes the enable, reads the stage flags, and writes the 32-bit offset and both halves of the deadline. An identification word can be read in either frame. The escalation is held by a three-state machine:

- `ST_ARMED`: no flags set.
- `ST_WARNED`: warning flag set.
- `ST_TRIPPED`: warning and reset flags set.

It has three named transitions:

- *fire1*: `ST_ARMED`→`ST_WARNED`, when enabled and the count reaches the deadline.
- *fire2*: `ST_WARNED`→`ST_TRIPPED`, under the same condition.
- *kick*: any state→`ST_ARMED`, on an explicit refresh.

Top module: `cmp_wdog`

## Requirements
- R1: While `por_n` is low and after it rises, the control/status word, the offset and both deadline halves read 0, and `warn_irq` and `sys_rst_req` are low.
- R2: The control frame (`bus_frame`=1) is laid out as follows. Offset 0x000 is control/status: bit 0 is the enable, bit 1 is the warning flag, bit 2 is the reset flag, and all other bits read 0. Offset 0x008 holds the offset, 0x010 the low deadline half and 0x014 the high deadline half. Reads have no side effects, and the two deadline halves may be written in either order without disturbing each other.
- R3: Offset 0xFCC reads the `ID_VALUE` parameter in both frames. Every other refresh-frame offset reads 0.
- R4: A write of any data to refresh-frame offset 0x000, to the control/status word, or to the offset register is an explicit refresh. From the next cycle, the deadline equals the count at the write plus the offset (the new offset, for an offset write), and both flags are clear.
- R5: Writes to refresh-frame offsets other than 0x000 change nothing.
- R6: When enabled with no flag set, if the count is greater than or equal to the deadline, the next cycle has the warning flag and `warn_irq` set. The deadline becomes that count plus the offset.
- R7: When enabled with the warning flag set, if the count is greater than or equal to the deadline, the next cycle also has the reset flag and `sys_rst_req` set. The reset flag is never set without the warning flag.
- R8: While the enable is 0, the flags do not change as the count passes the deadline.
- R9: Once set, the reset flag stays set until a refresh or `por_n` low, whatever the count does.
- R10: A direct write to a deadline half replaces that half. If the resulting deadline is at or below the count while the block is enabled, the stage fires on the following cycle. A half write takes priority over a hardware reload in the same cycle.
- R11: The refresh sum carries from the low half into the high half of the deadline.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, active low, clears all state |
| sys_count | input | 64 | Free-running system count |
| bus_frame | input | 1 | Frame select: 0 refresh, 1 control |
| bus_addr | input | 12 | Byte offset inside the frame |
| bus_we | input | 1 | Write strobe, one write per asserted cycle |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the addressed word, combinational |
| warn_irq | output | 1 | Warning interrupt, high while the warning flag is set |
| sys_rst_req | output | 1 | System reset request, high while the reset flag is set |

## Verification
The bench builds the block with the default 64-bit count and 32-bit offset. It sets its own identification value, so the ID read is told apart from any stray default. Because the bench drives the count directly rather than letting it run, it can place the count exactly one tick short of and exactly on each deadline. It can also reach values next to the 32-bit boundary, which exercises the carry into the high deadline half and a deadline moved below the count by a high-half write.

// File: rtl/wdog_pkg.sv
`timescale 1ns/1ps
package wdog_pkg;
    localparam int ADDR_W = 12;

    typedef enum logic [1:0] {
        ST_ARMED   = 2'd0,
        ST_WARNED  = 2'd1,
        ST_TRIPPED = 2'd2
    } wd_state_e;

    localparam logic [ADDR_W-1:0] A_KICK   = 12'h000;
    localparam logic [ADDR_W-1:0] A_CSR    = 12'h000;
    localparam logic [ADDR_W-1:0] A_OFFSET = 12'h008;
    localparam logic [ADDR_W-1:0] A_CMP_LO = 12'h010;
    localparam logic [ADDR_W-1:0] A_CMP_HI = 12'h014;
    localparam logic [ADDR_W-1:0] A_IDENT  = 12'hFCC;
endpackage

// File: rtl/wdog_bus_dec.sv
`timescale 1ns/1ps
module wdog_bus_dec
    import wdog_pkg::*;
#(
    parameter int DATA_W   = 32,
    parameter int CNT_W    = 64,
    parameter int OFS_W    = 32,
    parameter logic [DATA_W-1:0] ID_VALUE = '0
) (
    input  logic                 bus_frame,
    input  logic [ADDR_W-1:0]    bus_addr,
    input  logic                 bus_we,
    input  logic [DATA_W-1:0]    csr_val,
    input  logic [OFS_W-1:0]     offset_q,
    input  logic [CNT_W-1:0]     cmp_q,
    output logic                 wr_kick,
    output logic                 wr_csr,
    output logic                 wr_off,
    output logic                 wr_lo,
    output logic                 wr_hi,
    output logic [DATA_W-1:0]    rdata
);
    localparam int HALF = CNT_W / 2;

    assign wr_kick = bus_we && !bus_frame && (bus_addr == A_KICK);
    assign wr_csr  = bus_we &&  bus_frame && (bus_addr == A_CSR);
    assign wr_off  = bus_we &&  bus_frame && (bus_addr == A_OFFSET);
    assign wr_lo   = bus_we &&  bus_frame && (bus_addr == A_CMP_LO);
    assign wr_hi   = bus_we &&  bus_frame && (bus_addr == A_CMP_HI);

    always_comb begin
        rdata = '0;
        if (bus_addr == A_IDENT) begin
            rdata = ID_VALUE;
        end else if (bus_frame) begin
            case (bus_addr)
                A_CSR:    rdata = csr_val;
                A_OFFSET: rdata = DATA_W'(offset_q);
                A_CMP_LO: rdata = cmp_q[HALF-1:0];
                A_CMP_HI: rdata = cmp_q[CNT_W-1:HALF];
                default:  rdata = '0;
            endcase
        end
    end

    // R3: refresh frame never returns register contents outside the ID word
    always_comb begin
        if (!bus_frame && bus_addr != A_IDENT)
            assert_kick_frame_quiet_R3: assert (rdata == '0);
    end
endmodule

// File: rtl/wdog_cmp_unit.sv
`timescale 1ns/1ps
module wdog_cmp_unit #(
    parameter int CNT_W  = 64,
    parameter int OFS_W  = 32,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              por_n,
    input  logic [CNT_W-1:0]  sys_count,
    input  logic [DATA_W-1:0] wdata,
    input  logic              wr_off,
    input  logic              wr_lo,
    input  logic              wr_hi,
    input  logic              refresh,
    input  logic              reload,
    output logic [CNT_W-1:0]  cmp_q,
    output logic [OFS_W-1:0]  offset_q,
    output logic              due
);
    localparam int HALF = CNT_W / 2;

    logic [OFS_W-1:0] offset_nx;
    logic [CNT_W-1:0] rearm_val;

    assign offset_nx = wr_off ? wdata[OFS_W-1:0] : offset_q;
    assign rearm_val = sys_count + CNT_W'(offset_nx);
    assign due       = (sys_count >= cmp_q);

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            cmp_q    <= '0;
            offset_q <= '0;
        end else begin
            if (wr_off)
                offset_q <= wdata[OFS_W-1:0];
            if (wr_lo)
                cmp_q[HALF-1:0] <= wdata[HALF-1:0];
            else if (wr_hi)
                cmp_q[CNT_W-1:HALF] <= wdata[HALF-1:0];
            else if (refresh || reload)
                cmp_q <= rearm_val;
        end
    end

    // R2: deadline moves only through a half write, a refresh or a reload
    assert_cmp_hold_R2: assert property (@(posedge clk) disable iff (!por_n)
        !(wr_lo || wr_hi || refresh || reload) |=> $stable(cmp_q));

    // R10: a low-half write leaves the high half untouched
    assert_half_isolated_R10: assert property (@(posedge clk) disable iff (!por_n)
        wr_lo |=> $stable(cmp_q[CNT_W-1:HALF]));
endmodule

// File: rtl/wdog_stage_fsm.sv
`timescale 1ns/1ps
module wdog_stage_fsm
    import wdog_pkg::*;
(
    input  logic clk,
    input  logic por_n,
    input  logic enable,
    input  logic due,
    input  logic refresh,
    output logic warn,
    output logic trip,
    output logic reload
);
    wd_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        if (refresh) begin
            state_d = ST_ARMED;
        end else if (enable && due) begin
            unique case (state_q)
                ST_ARMED:   state_d = ST_WARNED;
                ST_WARNED:  state_d = ST_TRIPPED;
                ST_TRIPPED: state_d = ST_TRIPPED;
                default:    state_d = ST_ARMED;
            endcase
        end
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) state_q <= ST_ARMED;
        else        state_q <= state_d;
    end

    always_comb begin
        warn   = 1'b0;
        trip   = 1'b0;
        reload = 1'b0;
        unique case (state_q)
            ST_ARMED:   reload = enable && due && !refresh;
            ST_WARNED:  warn = 1'b1;
            ST_TRIPPED: begin warn = 1'b1; trip = 1'b1; end
            default:    ;
        endcase
    end

    // R8: no stage change while disabled except through a refresh
    assert_disabled_hold_R8: assert property (@(posedge clk) disable iff (!por_n)
        (!enable && !refresh) |=> $stable(state_q));

    // R9: tripped state is left only through a refresh
    assert_trip_sticky_R9: assert property (@(posedge clk) disable iff (!por_n)
        (state_q == ST_TRIPPED && !refresh) |=> state_q == ST_TRIPPED);

    // R7: the reset stage is never entered straight from armed
    assert_no_skip_R7: assert property (@(posedge clk) disable iff (!por_n)
        (state_q == ST_ARMED) |=> state_q != ST_TRIPPED);
endmodule

// File: rtl/cmp_wdog.sv
`timescale 1ns/1ps
module cmp_wdog
    import wdog_pkg::*;
#(
    parameter int CNT_W  = 64,
    parameter int OFS_W  = 32,
    parameter int DATA_W = 32,
    parameter logic [DATA_W-1:0] ID_VALUE = 32'h0002_1A57
) (
    input  logic              clk,
    input  logic              por_n,
    input  logic [CNT_W-1:0]  sys_count,
    input  logic              bus_frame,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              warn_irq,
    output logic              sys_rst_req
);
    logic wr_kick, wr_csr, wr_off, wr_lo, wr_hi;
    logic refresh, reload, due, en_q;
    logic [CNT_W-1:0]  cmp_q;
    logic [OFS_W-1:0]  offset_q;
    logic [DATA_W-1:0] csr_val;

    assign refresh = wr_kick || wr_csr || wr_off;
    assign csr_val = DATA_W'({sys_rst_req, warn_irq, en_q});

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n)      en_q <= 1'b0;
        else if (wr_csr) en_q <= bus_wdata[0];
    end

    wdog_bus_dec #(
        .DATA_W(DATA_W), .CNT_W(CNT_W), .OFS_W(OFS_W), .ID_VALUE(ID_VALUE)
    ) u_dec (
        .bus_frame(bus_frame), .bus_addr(bus_addr), .bus_we(bus_we),
        .csr_val(csr_val), .offset_q(offset_q), .cmp_q(cmp_q),
        .wr_kick(wr_kick), .wr_csr(wr_csr), .wr_off(wr_off),
        .wr_lo(wr_lo), .wr_hi(wr_hi), .rdata(bus_rdata)
    );

    wdog_cmp_unit #(
        .CNT_W(CNT_W), .OFS_W(OFS_W), .DATA_W(DATA_W)
    ) u_cmp (
        .clk(clk), .por_n(por_n), .sys_count(sys_count), .wdata(bus_wdata),
        .wr_off(wr_off), .wr_lo(wr_lo), .wr_hi(wr_hi),
        .refresh(refresh), .reload(reload),
        .cmp_q(cmp_q), .offset_q(offset_q), .due(due)
    );

    wdog_stage_fsm u_fsm (
        .clk(clk), .por_n(por_n), .enable(en_q), .due(due),
        .refresh(refresh), .warn(warn_irq), .trip(sys_rst_req), .reload(reload)
    );

    // R4: a refresh leaves both flags clear on the next cycle
    assert_refresh_clears_R4: assert property (@(posedge clk) disable iff (!por_n)
        refresh |=> (!warn_irq && !sys_rst_req));

    // R6: entering the warning stage re-arms one offset beyond the count
    assert_stage1_rearm_R6: assert property (@(posedge clk) disable iff (!por_n)
        ($rose(warn_irq) && !$past(wr_lo || wr_hi)) |->
        cmp_q == $past(sys_count) + CNT_W'($past(offset_q)));

    // R7: reset request rises only after the warning was already up
    assert_rst_order_R7: assert property (@(posedge clk) disable iff (!por_n)
        $rose(sys_rst_req) |-> $past(warn_irq));
endmodule

// File: tb/cmp_wdog_tb.sv
`timescale 1ns/1ps
module cmp_wdog_tb;
    localparam logic [31:0] TB_ID = 32'h5EED_0C1D;
    localparam int NVEC = 14;
    // entry: {is_read, frame, addr[11:0], data_or_expect[31:0]}
    localparam logic [45:0] VEC [NVEC] = '{
        {1'b0, 1'b1, 12'h008, 32'h0000_0100},
        {1'b1, 1'b1, 12'h008, 32'h0000_0100},
        {1'b1, 1'b1, 12'h010, 32'h0000_0100},
        {1'b1, 1'b1, 12'h014, 32'h0000_0000},
        {1'b0, 1'b1, 12'h014, 32'h0000_00AB},
        {1'b1, 1'b1, 12'h014, 32'h0000_00AB},
        {1'b1, 1'b1, 12'h010, 32'h0000_0100},
        {1'b0, 1'b1, 12'h010, 32'h0000_0055},
        {1'b1, 1'b1, 12'h010, 32'h0000_0055},
        {1'b1, 1'b1, 12'h014, 32'h0000_00AB},
        {1'b1, 1'b1, 12'h000, 32'h0000_0000},
        {1'b1, 1'b1, 12'hFCC, TB_ID},
        {1'b1, 1'b0, 12'hFCC, TB_ID},
        {1'b1, 1'b0, 12'h000, 32'h0000_0000}
    };

    logic        clk = 1'b0;
    logic        por_n = 1'b0;
    logic [63:0] sys_count = '0;
    logic        bus_frame = 1'b0;
    logic [11:0] bus_addr = '0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        warn_irq, sys_rst_req;
    int n_tests = 0;
    int n_fail = 0;

    always #2 clk = ~clk;

    cmp_wdog #(.ID_VALUE(TB_ID)) u_dut (
        .clk(clk), .por_n(por_n), .sys_count(sys_count),
        .bus_frame(bus_frame), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .warn_irq(warn_irq), .sys_rst_req(sys_rst_req)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic fr, input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_frame = fr; bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic fr, input logic [11:0] a, output logic [31:0] d);
        bus_frame = fr; bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic cycles(input int n);
        for (int k = 0; k < n; k++) @(negedge clk);
    endtask

    initial begin
        #400000;
        n_fail++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        logic [31:0] r;
        cycles(3);
        // R1: state held in reset
        rd(1'b1, 12'h000, r); chk("R1 csr in reset", r, 0);
        chk("R1 warn in reset", warn_irq, 0);
        por_n = 1'b1;
        cycles(2);
        rd(1'b1, 12'h000, r); chk("R1 csr", r, 0);
        rd(1'b1, 12'h008, r); chk("R1 offset", r, 0);
        rd(1'b1, 12'h010, r); chk("R1 cmp lo", r, 0);
        rd(1'b1, 12'h014, r); chk("R1 cmp hi", r, 0);
        chk("R1 warn_irq", warn_irq, 0);
        chk("R1 sys_rst_req", sys_rst_req, 0);

        // register map walk (R2, R3)
        for (int i = 0; i < NVEC; i++) begin
            if (!VEC[i][45]) begin
                wr(VEC[i][44], VEC[i][43:32], VEC[i][31:0]);
            end else begin
                rd(VEC[i][44], VEC[i][43:32], r);
                if (VEC[i][43:32] == 12'hFCC || !VEC[i][44])
                    chk("R3 table read", r, VEC[i][31:0]);
                else
                    chk("R2 table read", r, VEC[i][31:0]);
            end
        end
        chk("R8 no warn while disabled", warn_irq, 0);

        // first and second stage (R4, R6, R7)
        sys_count = 64'd1000;
        wr(1'b1, 12'h008, 32'd50);
        rd(1'b1, 12'h010, r); chk("R4 offset write rearms", r, 1050);
        wr(1'b1, 12'h000, 32'h1);
        rd(1'b1, 12'h000, r); chk("R2 csr enabled", r, 1);
        sys_count = 64'd1049;
        cycles(3);
        chk("R6 one tick short", warn_irq, 0);
        sys_count = 64'd1050;
        cycles(1);
        chk("R6 warn_irq on deadline", warn_irq, 1);
        rd(1'b1, 12'h010, r); chk("R6 rearmed deadline", r, 1100);
        rd(1'b1, 12'h000, r); chk("R6 csr warn", r, 3);
        sys_count = 64'd1099;
        cycles(3);
        chk("R7 one tick short", sys_rst_req, 0);
        sys_count = 64'd1100;
        cycles(1);
        chk("R7 sys_rst_req", sys_rst_req, 1);
        rd(1'b1, 12'h000, r); chk("R7 csr both flags", r, 7);
        sys_count = 64'd9000;
        cycles(5);
        chk("R9 reset flag held", sys_rst_req, 1);

        // disable clears and stalls (R4, R8)
        wr(1'b1, 12'h000, 32'h0);
        rd(1'b1, 12'h000, r); chk("R4 csr write clears flags", r, 0);
        sys_count = 64'd50000;
        cycles(4);
        chk("R8 disabled no fire", warn_irq, 0);

        // refresh-frame kick and ignored offsets (R4, R5)
        wr(1'b1, 12'h000, 32'h1);
        sys_count = 64'd50050;
        cycles(1);
        chk("R6 warn again", warn_irq, 1);
        wr(1'b0, 12'h004, 32'hDEAD_BEEF);
        chk("R5 stray refresh-frame write", warn_irq, 1);
        rd(1'b1, 12'h010, r); chk("R5 deadline unchanged", r, 50100);
        sys_count = 64'd50060;
        wr(1'b0, 12'h000, 32'h1234_5678);
        chk("R4 kick clears warn", warn_irq, 0);
        rd(1'b1, 12'h010, r); chk("R4 kick rearms", r, 50110);

        // carry and direct deadline write (R11, R10)
        sys_count = 64'h0000_0000_FFFF_FFF0;
        wr(1'b1, 12'h008, 32'h20);
        rd(1'b1, 12'h014, r); chk("R11 carry hi", r, 1);
        rd(1'b1, 12'h010, r); chk("R11 carry lo", r, 32'h10);
        wr(1'b1, 12'h014, 32'h0);
        chk("R10 not yet fired", warn_irq, 0);
        cycles(1);
        chk("R10 low deadline fires", warn_irq, 1);
        rd(1'b1, 12'h014, r); chk("R10 rearm hi", r, 1);

        // power-on reset clears tripped state (R9, R1)
        sys_count = 64'h0000_0001_0000_0010;
        cycles(1);
        chk("R9 tripped", sys_rst_req, 1);
        por_n = 1'b0;
        cycles(2);
        chk("R1 por clears reset flag", sys_rst_req, 0);
        por_n = 1'b1;
        cycles(1);
        rd(1'b1, 12'h000, r); chk("R1 csr after por", r, 0);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule